// File: doc/BRIEF.md
# Compact Extra-Form Instruction Expander

This block sits in the fetch path of a core that accepts 16-bit compressed encodings. It looks at one 16-bit code word at a time. When the word belongs to the group of extra compressed forms, it produces the equivalent 32-bit base instruction. That group covers byte and halfword loads and stores, the byte, halfword and word extensions, bitwise NOT and multiply. The decoder behind it then only needs to handle the base encoding for these forms.

A word that falls inside the group's encoding space but matches no form is marked illegal. A form whose optional subset is switched off by parameter is also marked illegal. A word outside the group is marked foreign, meaning it is left for another expander. Examples of foreign words are the classic compressed forms, the stack push/pop forms and full 32-bit words.

Results are held in an output register behind a valid/ready handshake. In steady state the block accepts one word per cycle. Every compressed register field of three bits names x8 to x15.

Top module: `cxExpand`

## Requirements
- R1: While reset is active and in the first cycle after it, outValid is 0, outInstr is 0 and inReady is 1.
- R2: A code with bits[1:0]=00, bits[15:10]=100000 becomes an unsigned byte load (funct3 100, opcode 0000011). The offset is {bit5, bit6}, so bit 6 carries offset bit 0. The destination comes from bits[4:2] and the base from bits[9:7].
- R3: A code with bits[15:10]=100001 and op 00 becomes a halfword load with offset {bit5, 0}. Bit 6 = 0 selects the unsigned form (funct3 101) and bit 6 = 1 selects the signed form (funct3 001).
- R4: Codes with bits[15:10]=100010 become a byte store (funct3 000, opcode 0100011, offset as in R2). Codes with 100011 and bit 6 = 0 become a halfword store (funct3 001, offset {bit5,0}). The data register comes from bits[4:2] and the base from bits[9:7]. A halfword store code with bit 6 = 1 is illegal.
- R5: A single-register code has bits[15:10]=100111, op 01 and a selector in bits[6:2]. Selector 11000 becomes ANDI rd,rd,255. Selector 11101 becomes XORI rd,rd,-1 (immediate 0xFFF).
- R6: With the bit-manipulation subset on, three selectors expand as follows. 11001 becomes the byte sign-extend (I-type immediate 0x604, funct3 001, opcode 0010011). 11011 becomes the halfword sign-extend (immediate 0x605). 11010 becomes the halfword zero-extend (funct7 0000100, rs2 x0, funct3 100, opcode 0111011 on 64-bit and 0110011 on 32-bit).
- R7: Selector 11100 becomes ADD.UW rd,rd,x0 (funct7 0000100, funct3 000, opcode 0111011). This expansion happens only when both the 64-bit option and the bit-manipulation subset are on.
- R8: A code with bits[15:10]=100111, bits[6:5]=10 and op 01 becomes MUL rd,rd,rs2 (funct7 0000001, funct3 000, opcode 0110011). The destination comes from bits[9:7] and rs2 from bits[4:2].
- R9: Several codes are illegal. These are op 00 with bits[15:13]=100 and bit 12 = 1, and selectors 11110 and 11111. Such codes set outIllegal with outInstr = 0.
- R10: Any other code, including op 01 with bits[15:10]=100111 and bits[6:5] of 00 or 01, sets outForeign with outIllegal = 0 and outInstr = 0.
- R11: While outValid is 1 and outReady is 0, outValid, outInstr and both flags hold their values.
- R12: inReady is 1 exactly when the output stage is empty or draining. With outReady held high, N back-to-back words take N cycles.
- R13: A three-bit register field f names register 8+f in every expansion.
- R14: A form whose subset is disabled is illegal. With bit-manipulation off, selectors 11001, 11010, 11011 and 11100 are illegal. With multiply off, the multiply code is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | A code word is offered |
| inInstr | input | 16 | Compressed code word |
| inReady | output | 1 | Word is taken on this edge when inValid is high |
| outValid | output | 1 | Output register holds a result |
| outReady | input | 1 | Consumer takes the result on this edge |
| outInstr | output | 32 | Expanded base instruction, 0 when flagged |
| outIllegal | output | 1 | Word is in the group's space but not a legal form |
| outForeign | output | 1 | Word is outside the group's space |

## Verification
Several structural rules are checked by assertions on every cycle. Both flags are never set together. A flagged result carries a zero word, and every legal result ends in opcode bits 11 with its rs1 field in x8..x15. A stalled output holds steady, and a drained stage with no new word goes empty. Only the bench's scenarios can show that each compressed form maps to the right base encoding. That includes the swapped offset bits, the halfword signed/unsigned split, the opcode chosen for the halfword zero-extend and the subset gating that turns forms illegal. The bench also measures one-word-per-cycle throughput.

// File: rtl/cxExpandPkg.sv
package cxExpandPkg;

  localparam int CLEN  = 16;
  localparam int ILEN  = 32;
  localparam int REGW  = 5;
  localparam int CREGW = 3;
  localparam int IMMW  = 12;

  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_OP    = 7'b0110011;
  localparam logic [6:0] OPC_OP32  = 7'b0111011;

  typedef enum logic [1:0] {
    KIND_OK      = 2'd0,
    KIND_ILLEGAL = 2'd1,
    KIND_FOREIGN = 2'd2
  } kind_e;

  typedef struct packed {
    logic capture;
    logic drain;
  } strobe_t;

  function automatic logic [REGW-1:0] cReg(input logic [CREGW-1:0] f);
    return {2'b01, f};
  endfunction

  function automatic logic [ILEN-1:0] iWord(input logic [IMMW-1:0] imm,
                                            input logic [REGW-1:0] rs1,
                                            input logic [2:0] f3,
                                            input logic [REGW-1:0] rd,
                                            input logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [ILEN-1:0] sWord(input logic [IMMW-1:0] imm,
                                            input logic [REGW-1:0] rs2,
                                            input logic [REGW-1:0] rs1,
                                            input logic [2:0] f3,
                                            input logic [6:0] opc);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
  endfunction

  function automatic logic [ILEN-1:0] rWord(input logic [6:0] f7,
                                            input logic [REGW-1:0] rs2,
                                            input logic [REGW-1:0] rs1,
                                            input logic [2:0] f3,
                                            input logic [REGW-1:0] rd,
                                            input logic [6:0] opc);
    return {f7, rs2, rs1, f3, rd, opc};
  endfunction

endpackage

// File: rtl/cxExpandDecode.sv
module cxExpandDecode
  import cxExpandPkg::*;
#(
  parameter bit BITMANIP_EN = 1'b1,
  parameter bit MUL_EN      = 1'b1,
  parameter bit IS_RV64     = 1'b1
) (
  input  logic [CLEN-1:0] cInstr,
  output logic [ILEN-1:0] wideInstr,
  output kind_e           kind
);

  localparam logic [6:0] ZEXTH_OPC = IS_RV64 ? OPC_OP32 : OPC_OP;
  localparam bit         ZEXTW_OK  = BITMANIP_EN && IS_RV64;

  logic [REGW-1:0] regLo;
  logic [REGW-1:0] regHi;
  logic [IMMW-1:0] byteOff;
  logic [IMMW-1:0] halfOff;
  logic            memSpace;
  logic            aluSpace;
  logic            legal;
  logic [ILEN-1:0] word;

  always_comb begin
    regLo    = cReg(cInstr[4:2]);
    regHi    = cReg(cInstr[9:7]);
    // offset bit 0 lives in bit 6, offset bit 1 in bit 5
    byteOff  = {{(IMMW-2){1'b0}}, cInstr[5], cInstr[6]};
    halfOff  = {{(IMMW-2){1'b0}}, cInstr[5], 1'b0};
    memSpace = (cInstr[1:0] == 2'b00) && (cInstr[15:13] == 3'b100);
    aluSpace = (cInstr[1:0] == 2'b01) && (cInstr[15:10] == 6'b100111) && cInstr[6];
  end

  always_comb begin
    legal = 1'b0;
    word  = '0;
    if (memSpace) begin
      unique case (cInstr[12:10])
        3'b000: begin
          legal = 1'b1;
          word  = iWord(byteOff, regHi, 3'b100, regLo, OPC_LOAD);
        end
        3'b001: begin
          legal = 1'b1;
          word  = iWord(halfOff, regHi, cInstr[6] ? 3'b001 : 3'b101, regLo, OPC_LOAD);
        end
        3'b010: begin
          legal = 1'b1;
          word  = sWord(byteOff, regLo, regHi, 3'b000, OPC_STORE);
        end
        3'b011: begin
          legal = !cInstr[6];
          word  = sWord(halfOff, regLo, regHi, 3'b001, OPC_STORE);
        end
        default: begin
          legal = 1'b0;
          word  = '0;
        end
      endcase
    end else if (aluSpace) begin
      if (!cInstr[5]) begin
        legal = MUL_EN;
        word  = rWord(7'b0000001, regLo, regHi, 3'b000, regHi, OPC_OP);
      end else begin
        unique case (cInstr[4:2])
          3'b000: begin
            legal = 1'b1;
            word  = iWord(12'h0FF, regHi, 3'b111, regHi, OPC_IMM);
          end
          3'b001: begin
            legal = BITMANIP_EN;
            word  = iWord(12'h604, regHi, 3'b001, regHi, OPC_IMM);
          end
          3'b010: begin
            legal = BITMANIP_EN;
            word  = rWord(7'b0000100, 5'd0, regHi, 3'b100, regHi, ZEXTH_OPC);
          end
          3'b011: begin
            legal = BITMANIP_EN;
            word  = iWord(12'h605, regHi, 3'b001, regHi, OPC_IMM);
          end
          3'b100: begin
            legal = ZEXTW_OK;
            word  = rWord(7'b0000100, 5'd0, regHi, 3'b000, regHi, OPC_OP32);
          end
          3'b101: begin
            legal = 1'b1;
            word  = iWord(12'hFFF, regHi, 3'b100, regHi, OPC_IMM);
          end
          default: begin
            legal = 1'b0;
            word  = '0;
          end
        endcase
      end
    end
  end

  always_comb begin
    if (!memSpace && !aluSpace) begin
      kind      = KIND_FOREIGN;
      wideInstr = '0;
    end else if (!legal) begin
      kind      = KIND_ILLEGAL;
      wideInstr = '0;
    end else begin
      kind      = KIND_OK;
      wideInstr = word;
    end
  end

endmodule

// File: rtl/cxExpandDatapath.sv
module cxExpandDatapath
  import cxExpandPkg::*;
#(
  parameter bit BITMANIP_EN = 1'b1,
  parameter bit MUL_EN      = 1'b1,
  parameter bit IS_RV64     = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  strobe_t         strobe,
  input  logic [CLEN-1:0] inInstr,
  output logic [ILEN-1:0] dataInstr,
  output kind_e           dataKind
);

  logic [ILEN-1:0] decInstr;
  kind_e           decKind;

  cxExpandDecode #(
    .BITMANIP_EN(BITMANIP_EN),
    .MUL_EN     (MUL_EN),
    .IS_RV64    (IS_RV64)
  ) u_decode (
    .cInstr   (inInstr),
    .wideInstr(decInstr),
    .kind     (decKind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dataInstr <= '0;
      dataKind  <= KIND_OK;
    end else if (strobe.capture) begin
      dataInstr <= decInstr;
      dataKind  <= decKind;
    end else if (strobe.drain) begin
      dataInstr <= '0;
      dataKind  <= KIND_OK;
    end
  end

  // R9: flagged results never carry a word
  a_r9_flag_zero: assert property (@(posedge clk) disable iff (rst)
    (dataKind != KIND_OK) |-> (dataInstr == '0));

  // R13: every legal result reads rs1 from x8..x15 and is a full-width opcode
  a_r13_reg_window: assert property (@(posedge clk) disable iff (rst)
    (dataKind == KIND_OK && dataInstr != '0) |->
      (dataInstr[19:18] == 2'b01 && dataInstr[1:0] == 2'b11));

endmodule

// File: rtl/cxExpandCtrl.sv
module cxExpandCtrl
  import cxExpandPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  input  logic    outReady,
  output logic    inReady,
  output logic    outValid,
  output strobe_t strobe
);

  always_comb begin
    inReady        = !outValid || outReady;
    strobe.capture = inValid && inReady;
    strobe.drain   = outValid && outReady && !strobe.capture;
  end

  always_ff @(posedge clk) begin
    if (rst)                 outValid <= 1'b0;
    else if (strobe.capture) outValid <= 1'b1;
    else if (strobe.drain)   outValid <= 1'b0;
  end

  // R12: a drained stage with nothing offered goes empty
  a_r12_drain_empty: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && !inValid) |=> !outValid);

  // R12: an offered word on an open stage is always held next cycle
  a_r12_accept_fill: assert property (@(posedge clk) disable iff (rst)
    (inValid && (!outValid || outReady)) |=> outValid);

endmodule

// File: rtl/cxExpand.sv
module cxExpand
  import cxExpandPkg::*;
#(
  parameter bit BITMANIP_EN = 1'b1,
  parameter bit MUL_EN      = 1'b1,
  parameter bit IS_RV64     = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [15:0] inInstr,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] outInstr,
  output logic        outIllegal,
  output logic        outForeign
);

  strobe_t strobe;
  kind_e   dataKind;

  cxExpandCtrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  cxExpandDatapath #(
    .BITMANIP_EN(BITMANIP_EN),
    .MUL_EN     (MUL_EN),
    .IS_RV64    (IS_RV64)
  ) u_data (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .inInstr  (inInstr),
    .dataInstr(outInstr),
    .dataKind (dataKind)
  );

  assign outIllegal = (dataKind == KIND_ILLEGAL);
  assign outForeign = (dataKind == KIND_FOREIGN);

  // R11: a stalled result is held unchanged
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=>
      (outValid && $stable(outInstr) && $stable(outIllegal) && $stable(outForeign)));

  // R10: the two flags never appear together
  a_r10_flag_excl: assert property (@(posedge clk) disable iff (rst)
    !(outIllegal && outForeign));

  // R1: an empty stage shows no flags and no word
  a_r1_idle_clean: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (outInstr == '0 && !outIllegal && !outForeign));

endmodule

// File: tb/cxExpand_tb.sv
`timescale 1ns/1ps
module cxExpand_tb;

  typedef struct {
    logic [31:0] w;
    logic        ill;
    logic        frn;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] inInstr = '0;
  logic        inReady;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] outInstr;
  logic        outIllegal;
  logic        outForeign;

  logic        liteInValid = 1'b0;
  logic [15:0] liteInInstr = '0;
  logic        liteInReady;
  logic        liteOutValid;
  logic [31:0] liteOutInstr;
  logic        liteOutIllegal;
  logic        liteOutForeign;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int readyMode = 0;
  bit finished = 1'b0;
  exp_t expQ[$];

  always #4 clk = ~clk;

  cxExpand u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inInstr(inInstr), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outInstr(outInstr),
    .outIllegal(outIllegal), .outForeign(outForeign)
  );

  cxExpand #(.BITMANIP_EN(1'b0), .MUL_EN(1'b0), .IS_RV64(1'b0)) u_lite (
    .clk(clk), .rst(rst), .inValid(liteInValid), .inInstr(liteInInstr), .inReady(liteInReady),
    .outValid(liteOutValid), .outReady(1'b1), .outInstr(liteOutInstr),
    .outIllegal(liteOutIllegal), .outForeign(liteOutForeign)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #2;
    outReady = (readyMode == 0) || (readyMode == 1 && (cyc % 3) != 0);
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected encodings built from requirement field layouts
  function automatic logic [31:0] encI(input logic [11:0] imm, input int rs1, input logic [2:0] f3, input int rd, input logic [6:0] op);
    return {imm, rs1[4:0], f3, rd[4:0], op};
  endfunction
  function automatic logic [31:0] encS(input logic [11:0] imm, input int rs2, input int rs1, input logic [2:0] f3);
    return {imm[11:5], rs2[4:0], rs1[4:0], f3, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] encR(input logic [6:0] f7, input int rs2, input int rs1, input logic [2:0] f3, input int rd, input logic [6:0] op);
    return {f7, rs2[4:0], rs1[4:0], f3, rd[4:0], op};
  endfunction
  function automatic logic [15:0] cMem(input logic [2:0] sub, input logic [2:0] base, input logic b6, input logic b5, input logic [2:0] lo);
    return {3'b100, sub, base, b6, b5, lo, 2'b00};
  endfunction
  function automatic logic [15:0] cAlu(input logic [2:0] r, input logic [4:0] sel);
    return {6'b100111, r, sel, 2'b01};
  endfunction

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic send(input logic [15:0] c, input logic [31:0] w, input logic ill, input logic frn, input string tag);
    exp_t e;
    bit ok;
    e.w = w; e.ill = ill; e.frn = frn; e.tag = tag;
    inValid = 1'b1;
    inInstr = c;
    expQ.push_back(e);
    do begin
      #1 ok = inReady;
      @(negedge clk);
    end while (!ok);
    inValid = 1'b0;
  endtask

  // monitor: compares each transferred result and the hold rule
  logic        heldPrev = 1'b0;
  logic [33:0] heldVal = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (heldPrev)
        check(outValid && {outIllegal, outForeign, outInstr} == heldVal, "R11 hold",
              {outIllegal, outForeign, outInstr[29:0]}, heldVal[31:0]);
      heldPrev = outValid && !outReady;
      heldVal  = {outIllegal, outForeign, outInstr};
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R12 unexpected result", outInstr, 32'h0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(outInstr == e.w && outIllegal == e.ill && outForeign == e.frn, e.tag,
                {outIllegal, outForeign, outInstr[29:0]}, {e.ill, e.frn, e.w[29:0]});
        end
      end
    end
  end

  task automatic liteCheck(input logic [15:0] c, input logic expIll, input logic [31:0] expW, input string tag);
    liteInValid = 1'b1;
    liteInInstr = c;
    @(negedge clk);
    liteInValid = 1'b0;
    check(liteOutValid && liteOutIllegal == expIll && !liteOutForeign && liteOutInstr == expW, tag,
          liteOutInstr, expW);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!outValid && outInstr == 32'h0, "R1 reset outputs", outInstr, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(inReady && !outValid, "R1 ready after reset", {31'h0, inReady}, 32'h1);

    // R2 byte load, swapped offset bits; R13 register mapping
    send(cMem(3'b000, 3'd5, 1'b0, 1'b1, 3'd3), encI(12'd2, 13, 3'b100, 11, 7'h03), 0, 0, "R2 lbu off2");
    send(cMem(3'b000, 3'd0, 1'b1, 1'b0, 3'd7), encI(12'd1, 8, 3'b100, 15, 7'h03), 0, 0, "R2 R13 lbu off1");
    send(cMem(3'b000, 3'd2, 1'b1, 1'b1, 3'd1), encI(12'd3, 10, 3'b100, 9, 7'h03), 0, 0, "R2 lbu off3");
    // R3 halfword loads
    send(cMem(3'b001, 3'd6, 1'b0, 1'b1, 3'd1), encI(12'd2, 14, 3'b101, 9, 7'h03), 0, 0, "R3 lhu");
    send(cMem(3'b001, 3'd7, 1'b1, 1'b0, 3'd0), encI(12'd0, 15, 3'b001, 8, 7'h03), 0, 0, "R3 lh");
    // R4 stores
    send(cMem(3'b010, 3'd4, 1'b1, 1'b1, 3'd2), encS(12'd3, 10, 12, 3'b000), 0, 0, "R4 sb");
    send(cMem(3'b011, 3'd0, 1'b0, 1'b1, 3'd7), encS(12'd2, 15, 8, 3'b001), 0, 0, "R4 sh");
    send(cMem(3'b011, 3'd0, 1'b1, 1'b1, 3'd7), 32'h0, 1, 0, "R4 sh bit6 illegal");

    readyMode = 1;
    // R5 always-present single-register forms
    send(cAlu(3'd2, 5'b11000), encI(12'h0FF, 10, 3'b111, 10, 7'h13), 0, 0, "R5 zext.b");
    send(cAlu(3'd5, 5'b11101), encI(12'hFFF, 13, 3'b100, 13, 7'h13), 0, 0, "R5 not");
    // R6 bit-manipulation forms (64-bit default)
    send(cAlu(3'd1, 5'b11001), encI(12'h604, 9, 3'b001, 9, 7'h13), 0, 0, "R6 sext.b");
    send(cAlu(3'd6, 5'b11011), encI(12'h605, 14, 3'b001, 14, 7'h13), 0, 0, "R6 sext.h");
    send(cAlu(3'd4, 5'b11010), encR(7'b0000100, 0, 12, 3'b100, 12, 7'h3B), 0, 0, "R6 zext.h");
    // R7 word zero-extend
    send(cAlu(3'd7, 5'b11100), encR(7'b0000100, 0, 15, 3'b000, 15, 7'h3B), 0, 0, "R7 zext.w");
    // R8 multiply
    send({6'b100111, 3'd3, 2'b10, 3'd6, 2'b01}, encR(7'b0000001, 14, 11, 3'b000, 11, 7'h33), 0, 0, "R8 mul");
    // R9 illegal codes
    send(16'h9000, 32'h0, 1, 0, "R9 q0 bit12 illegal");
    send(cAlu(3'd0, 5'b11110), 32'h0, 1, 0, "R9 sel 11110 illegal");
    send(cAlu(3'd3, 5'b11111), 32'h0, 1, 0, "R9 sel 11111 illegal");
    // R10 foreign codes
    send(16'h4501, 32'h0, 0, 1, "R10 classic form foreign");
    send({6'b100111, 3'd1, 2'b00, 3'd2, 2'b01}, 32'h0, 0, 1, "R10 funct2 00 foreign");
    send({6'b100111, 3'd1, 2'b01, 3'd2, 2'b01}, 32'h0, 0, 1, "R10 funct2 01 foreign");
    send(16'h0003, 32'h0, 0, 1, "R10 full-width foreign");

    // R11/R12: full stall, input blocked
    readyMode = 2;
    @(negedge clk);
    @(negedge clk);
    send(cAlu(3'd0, 5'b11000), encI(12'h0FF, 8, 3'b111, 8, 7'h13), 0, 0, "R11 stalled item");
    inValid = 1'b1;
    inInstr = cAlu(3'd1, 5'b11101);
    for (int i = 0; i < 3; i++) begin
      #1;
      check(!inReady && outValid, "R12 blocked while stalled", {30'h0, inReady, outValid}, 32'h1);
      @(negedge clk);
    end
    inValid = 1'b0;
    readyMode = 0;
    repeat (3) @(negedge clk);

    // R12: throughput, one word per cycle
    c0 = cyc;
    send(cAlu(3'd2, 5'b11101), encI(12'hFFF, 10, 3'b100, 10, 7'h13), 0, 0, "R12 burst 0");
    send(cAlu(3'd3, 5'b11101), encI(12'hFFF, 11, 3'b100, 11, 7'h13), 0, 0, "R12 burst 1");
    send(cAlu(3'd4, 5'b11000), encI(12'h0FF, 12, 3'b111, 12, 7'h13), 0, 0, "R12 burst 2");
    send(cAlu(3'd5, 5'b11000), encI(12'h0FF, 13, 3'b111, 13, 7'h13), 0, 0, "R12 burst 3");
    check(cyc - c0 == 4, "R12 burst cycles", cyc - c0, 32'd4);

    for (int i = 0; i < 20 && (expQ.size() != 0 || outValid); i++) @(negedge clk);
    check(expQ.size() == 0 && !outValid, "R12 all results drained", expQ.size(), 32'h0);

    // R14: subsets disabled on the second instance
    liteCheck(cAlu(3'd1, 5'b11001), 1, 32'h0, "R14 sext.b off");
    liteCheck(cAlu(3'd1, 5'b11010), 1, 32'h0, "R14 zext.h off");
    liteCheck(cAlu(3'd1, 5'b11011), 1, 32'h0, "R14 sext.h off");
    liteCheck(cAlu(3'd1, 5'b11100), 1, 32'h0, "R14 R7 zext.w off");
    liteCheck({6'b100111, 3'd3, 2'b10, 3'd6, 2'b01}, 1, 32'h0, "R14 mul off");
    liteCheck(cAlu(3'd2, 5'b11000), 0, encI(12'h0FF, 10, 3'b111, 10, 7'h13), "R14 R5 zext.b stays legal");

    finishRun();
  end

endmodule